// File: doc/BRIEF.md
# Programmable Timer/Counter Channel

This block is one channel of a general-purpose timer. A counter, parameterized to 16 or 32 bits, counts up on a tick chosen from four prescaled taps of the system clock (divide by 2, 8, 32 or 128) or from an externally supplied slow tick. Two compare registers, A and C, are checked against the counter each time it steps. The channel runs free and wraps at its maximum, reloads to zero after matching C to give a periodic event, or halts on a C match to give a one-shot event. The A and C matches also drive a waveform output.

Software controls the channel through a small synchronous register bus. It can write the mode and compare values, issue enable, disable and retrigger commands, set and clear interrupt mask bits, and read back the mask, the status and the live count. Reads return data one cycle after the read strobe. Reading the status clears its event flags. The interrupt line is high while any unmasked event flag is set.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the counter is 0, the channel is stopped, the mode, compare, mask and flag registers are 0, and both wave_out and irq are low.
- R2: Mode bits [2:0] pick the count tick: 0, 1, 2 and 3 give the system clock divided by 2, 8, 32 and 128, 4 gives the slow_tick input, and 5 to 7 give no tick. After a trigger at edge T, a divided tick with divisor D makes the count equal k from edge T+D*k onward.
- R3: A write to the command register (address 1) enables the clock with bit 0, disables it with bit 1 and triggers with bit 2. Disable wins over enable. A trigger zeroes the counter and the prescaler without starting the clock, and enable plus trigger starts counting from zero. A stopped counter holds its value.
- R4: When mode bit 3 is clear, the counter ignores C for reloading and wraps from its all-ones value to 0. The wrap sets the overflow flag (status bit 2).
- R5: When mode bit 3 is set, a step taken while the counter equals C loads 0, which gives a period of C+1 ticks. Each time the counter reaches C, the C flag (status bit 0) is set.
- R6: When mode bit 4 is set, the step that brings the counter to C clears the clock enable. The counter then holds C until a new enable command, and status bit 3 reads 0 meanwhile.
- R7: wave_out goes high on the step that brings the counter to A and low on the step that brings it to C. When both match on the same step, the C match wins. A trigger leaves wave_out unchanged.
- R8: A write to address 4 sets mask bits, a write to address 5 clears them, and address 6 reads the 3-bit mask. irq is high exactly while some flag is set whose mask bit is also set.
- R9: Status (address 7) reads the C flag in bit 0, the A-match flag in bit 1, the overflow flag in bit 2 and the clock-running state in bit 3. A status read clears the flags, but an event in the same cycle leaves its flag set.
- R10: Addresses 0 (mode, 5 bits), 2 (compare A) and 3 (compare C) read back as written, and address 8 returns the count. Read data appears the cycle after bus_rd, and write-only addresses read as 0.
- R11: Parameter CNT_W selects a 16- or 32-bit counter and compare registers, and any other value is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, source of the prescaled taps |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow clock period |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| wave_out | output | 1 | Compare-driven waveform |
| irq | output | 1 | Interrupt request, OR of the masked flags |

## Verification
The bench builds two channels side by side on the same bus: one with the default 16-bit counter and one with CNT_W set to 32. The 16-bit build makes a full wrap reachable with the divide-by-2 tap in about 131 thousand cycles, so the overflow flag and the A/C waveform can be checked over a real wrap. At that same point the 32-bit build must read 0x10000 and not 0. The two builds also differ in how many bits of a compare write they keep, which gives a direct check of the width variant.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Register word addresses
   typedef enum logic [3:0] {
      RA_MODE = 4'd0,
      RA_CMD  = 4'd1,
      RA_CMPA = 4'd2,
      RA_CMPC = 4'd3,
      RA_IEN  = 4'd4,
      RA_IDIS = 4'd5,
      RA_MASK = 4'd6,
      RA_STAT = 4'd7,
      RA_CNT  = 4'd8
   } reg_addr_e;

   localparam int ADDR_W = 4;

   // Prescaler taps: divisor of tap i is 2**TAP_LOG2[i]
   localparam int NUM_TAPS = 4;
   localparam int TAP_LOG2 [NUM_TAPS] = '{1, 3, 5, 7};
   localparam int PRE_W = 7;
   localparam logic [2:0] SEL_SLOW = 3'd4;

   // Command bits
   localparam int CMD_EN   = 0;
   localparam int CMD_DIS  = 1;
   localparam int CMD_TRIG = 2;

   // Flag / status bits
   localparam int NUM_FLAGS = 3;
   localparam int FLAG_C    = 0;
   localparam int FLAG_A    = 1;
   localparam int FLAG_OVF  = 2;

   // Mode register layout: {stop_c, auto_rst, sel[2:0]}
   typedef struct packed {
      logic       stop_c;
      logic       auto_rst;
      logic [2:0] sel;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int PW = PRE_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       slow_tick,
   input  logic [2:0] sel,
   output logic       pre_tick
);

   localparam int IDX_W = $clog2(NUM_TAPS);

   logic [PW-1:0]       pre_q;
   logic [NUM_TAPS-1:0] tap;

   always_ff @(posedge clk) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      if (TAP_LOG2[i] > PW) begin : g_bad
         $error("prescaler too narrow for tap");
      end
      assign tap[i] = &pre_q[TAP_LOG2[i]-1:0];
   end

   always_comb begin
      if (sel < 3'(NUM_TAPS))   pre_tick = tap[sel[IDX_W-1:0]];
      else if (sel == SEL_SLOW) pre_tick = slow_tick;
      else                      pre_tick = 1'b0;
   end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic             cmd_en,
   input  logic             cmd_dis,
   input  logic             cmd_trig,
   input  logic             auto_rst,
   input  logic             stop_c,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_c,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             ev_c,
   output logic             ev_a,
   output logic             ev_ovf,
   output logic             wave_out
);

   logic             step;
   logic             reload;
   logic [CNT_W-1:0] nxt;

   assign step   = running && pre_tick && !cmd_trig;
   assign reload = auto_rst && (cnt == cmp_c);
   assign nxt    = reload ? '0 : cnt + 1'b1;

   assign ev_c   = step && (nxt == cmp_c);
   assign ev_a   = step && (nxt == cmp_a);
   assign ev_ovf = step && !reload && (&cnt);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (cmd_trig) cnt <= '0;
      else if (step)     cnt <= nxt;
   end

   // Commands outrank the stop-on-C condition; disable outranks enable
   always_ff @(posedge clk) begin
      if (!rst_n)              running <= 1'b0;
      else if (cmd_dis)        running <= 1'b0;
      else if (cmd_en)         running <= 1'b1;
      else if (ev_c && stop_c) running <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    wave_out <= 1'b0;
      else if (ev_c) wave_out <= 1'b0;
      else if (ev_a) wave_out <= 1'b1;
   end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 bus_rd,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 running,
   input  logic                 ev_c,
   input  logic                 ev_a,
   input  logic                 ev_ovf,
   output mode_t                mode,
   output logic [CNT_W-1:0]     cmp_a,
   output logic [CNT_W-1:0]     cmp_c,
   output logic                 cmd_en,
   output logic                 cmd_dis,
   output logic                 cmd_trig,
   output logic [NUM_FLAGS-1:0] flags,
   output logic [NUM_FLAGS-1:0] mask,
   output logic                 st_clr
);

   logic wr_mode, wr_cmd, wr_cmpa, wr_cmpc, wr_ien, wr_idis;
   logic [NUM_FLAGS-1:0] ev_vec;

   assign wr_mode = bus_wr && (bus_addr == RA_MODE);
   assign wr_cmd  = bus_wr && (bus_addr == RA_CMD);
   assign wr_cmpa = bus_wr && (bus_addr == RA_CMPA);
   assign wr_cmpc = bus_wr && (bus_addr == RA_CMPC);
   assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
   assign wr_idis = bus_wr && (bus_addr == RA_IDIS);
   assign st_clr  = bus_rd && (bus_addr == RA_STAT);

   assign cmd_en   = wr_cmd && bus_wdata[CMD_EN];
   assign cmd_dis  = wr_cmd && bus_wdata[CMD_DIS];
   assign cmd_trig = wr_cmd && bus_wdata[CMD_TRIG];

   always_comb begin
      ev_vec           = '0;
      ev_vec[FLAG_C]   = ev_c;
      ev_vec[FLAG_A]   = ev_a;
      ev_vec[FLAG_OVF] = ev_ovf;
   end

   if (DATA_W > CNT_W) begin : g_wide_bus
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode  <= '0;
         cmp_a <= '0;
         cmp_c <= '0;
         mask  <= '0;
      end else begin
         if (wr_mode) mode  <= mode_t'(bus_wdata[MODE_W-1:0]);
         if (wr_cmpa) cmp_a <= bus_wdata[CNT_W-1:0];
         if (wr_cmpc) cmp_c <= bus_wdata[CNT_W-1:0];
         if (wr_ien)       mask <= mask | bus_wdata[NUM_FLAGS-1:0];
         else if (wr_idis) mask <= mask & ~bus_wdata[NUM_FLAGS-1:0];
      end
   end

   // A new event in the clearing cycle survives the clear
   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (st_clr ? '0 : flags) | ev_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (bus_addr)
            RA_MODE: bus_rdata <= DATA_W'(mode);
            RA_CMPA: bus_rdata <= DATA_W'(cmp_a);
            RA_CMPC: bus_rdata <= DATA_W'(cmp_c);
            RA_MASK: bus_rdata <= DATA_W'(mask);
            RA_STAT: bus_rdata <= DATA_W'({running, flags});
            RA_CNT:  bus_rdata <= DATA_W'(cnt);
            default: bus_rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic [3:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wave_out,
   output logic              irq
);

   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("CNT_W must be 16 or 32");
   end
   if (DATA_W < CNT_W || DATA_W < 8) begin : g_bad_bus
      $error("DATA_W too narrow for the counter");
   end

   mode_t                mode;
   logic [CNT_W-1:0]     cmp_a, cmp_c, cnt;
   logic                 cmd_en, cmd_dis, cmd_trig;
   logic                 running, pre_tick;
   logic                 ev_c, ev_a, ev_ovf;
   logic [NUM_FLAGS-1:0] flags, mask;
   logic                 st_clr;

   tmr_prescale #(.PW(PRE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_trig),
      .slow_tick (slow_tick),
      .sel       (mode.sel),
      .pre_tick  (pre_tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_tick (pre_tick),
      .cmd_en   (cmd_en),
      .cmd_dis  (cmd_dis),
      .cmd_trig (cmd_trig),
      .auto_rst (mode.auto_rst),
      .stop_c   (mode.stop_c),
      .cmp_a    (cmp_a),
      .cmp_c    (cmp_c),
      .cnt      (cnt),
      .running  (running),
      .ev_c     (ev_c),
      .ev_a     (ev_a),
      .ev_ovf   (ev_ovf),
      .wave_out (wave_out)
   );

   tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .cnt       (cnt),
      .running   (running),
      .ev_c      (ev_c),
      .ev_a      (ev_a),
      .ev_ovf    (ev_ovf),
      .mode      (mode),
      .cmp_a     (cmp_a),
      .cmp_c     (cmp_c),
      .cmd_en    (cmd_en),
      .cmd_dis   (cmd_dis),
      .cmd_trig  (cmd_trig),
      .flags     (flags),
      .mask      (mask),
      .st_clr    (st_clr)
   );

   assign irq = |(flags & mask);

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_en,
   input logic             cmd_dis,
   input logic             cmd_trig,
   input logic             running,
   input logic             pre_tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_c,
   input logic             auto_rst,
   input logic             stop_c,
   input logic             ev_c,
   input logic             wave_out,
   input logic [2:0]       flags,
   input logic             st_clr
);

   AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_dis |=> !running); // R3

   AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_trig |=> (cnt == '0)); // R3

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(running && pre_tick) && !cmd_trig) |=> $stable(cnt)); // R2

   AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && pre_tick && !cmd_trig && auto_rst && cnt == cmp_c) |=> (cnt == '0)); // R5

   AST_STOP_ON_C: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_c && stop_c && !cmd_en) |=> !running); // R6

   AST_WAVE_LOW_ON_C: assert property (@(posedge clk) disable iff (!rst_n)
      ev_c |=> !wave_out); // R7

   AST_FLAG_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ev_c |=> flags[0]); // R9

   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr && !ev_c) |=> !flags[0]); // R9

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_en   (cmd_en),
   .cmd_dis  (cmd_dis),
   .cmd_trig (cmd_trig),
   .running  (running),
   .pre_tick (pre_tick),
   .cnt      (cnt),
   .cmp_c    (cmp_c),
   .auto_rst (mode.auto_rst),
   .stop_c   (mode.stop_c),
   .ev_c     (ev_c),
   .wave_out (wave_out),
   .flags    (flags),
   .st_clr   (st_clr)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

   localparam int WD_CYCLES = 195000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] rdata16, rdata32;
   logic        wave16, wave32, irq16, irq32;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic [31:0] v;

   always #5 clk = ~clk;

   tmr_channel #(.CNT_W(16), .DATA_W(32)) u_tmr_channel (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata16), .wave_out(wave16), .irq(irq16)
   );

   tmr_channel #(.CNT_W(32), .DATA_W(32)) u_tmr_channel_w32 (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata32), .wave_out(wave32), .irq(irq32)
   );

   typedef struct packed {
      logic [2:0]  sel;
      logic [15:0] wait_n;
      logic [15:0] exp;
   } vec_t;

   // Clock-select vectors: count after wait_n idle cycles is wait_n / divisor
   localparam vec_t VECS [8] = '{
      '{3'd0, 16'd10,  16'd5},
      '{3'd0, 16'd1,   16'd0},
      '{3'd1, 16'd20,  16'd2},
      '{3'd1, 16'd7,   16'd0},
      '{3'd1, 16'd8,   16'd1},
      '{3'd2, 16'd70,  16'd2},
      '{3'd3, 16'd300, 16'd2},
      '{3'd5, 16'd50,  16'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = rdata16;
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd8, v); chk("R1 count", v, 0);
      rd(4'd7, v); chk("R1 status", v, 0);
      rd(4'd6, v); chk("R1 mask", v, 0);
      rd(4'd0, v); chk("R1 mode", v, 0);
      chk("R1 wave", {31'd0, wave16}, 0);
      chk("R1 irq", {31'd0, irq16}, 0);

      // R2 clock-select table
      for (int i = 0; i < 8; i++) begin
         wr(4'd0, {29'd0, VECS[i].sel});
         wr(4'd1, 32'h5);
         idle(int'(VECS[i].wait_n));
         rd(4'd8, v);
         chk("R2 prescaled count", v, {16'd0, VECS[i].exp});
         wr(4'd1, 32'h2);
      end

      // R2 slow tick source
      wr(4'd0, 32'h4);
      wr(4'd1, 32'h5);
      for (int i = 0; i < 3; i++) begin
         slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
         idle(2);
      end
      rd(4'd8, v); chk("R2 slow tick count", v, 3);
      wr(4'd1, 32'h2);

      // R3 commands
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h5);
      idle(10);
      wr(4'd1, 32'h2);
      idle(20);
      rd(4'd8, v); chk("R3 held after disable", v, 5);
      rd(4'd7, v); chk("R3 stopped bit", v & 32'h8, 0);
      wr(4'd1, 32'h3);
      rd(4'd7, v); chk("R3 disable wins", v & 32'h8, 0);
      wr(4'd1, 32'h4);
      rd(4'd8, v); chk("R3 trigger zeroes", v, 0);
      idle(10);
      rd(4'd8, v); chk("R3 trigger alone does not start", v, 0);
      wr(4'd1, 32'h1);
      rd(4'd7, v); chk("R3 enable runs", v & 32'h8, 32'h8);
      wr(4'd1, 32'h2);

      // R5 auto-reload on C
      rd(4'd7, v);
      wr(4'd3, 32'd4);
      wr(4'd0, 32'h8);
      wr(4'd1, 32'h5);
      idle(19);
      rd(4'd8, v); chk("R5 period C+1 (9 steps)", v, 4);
      idle(2);
      rd(4'd8, v); chk("R5 period C+1 (11 steps)", v, 1);
      wr(4'd1, 32'h2);
      rd(4'd7, v); chk("R5 C and A flags, no overflow", v & 32'hF, 32'h3);
      rd(4'd7, v); chk("R9 status read clears", v, 0);

      // R6 one-shot stop on C
      wr(4'd3, 32'd3);
      wr(4'd0, 32'h10);
      rd(4'd7, v);
      wr(4'd1, 32'h5);
      idle(20);
      rd(4'd8, v); chk("R6 holds at C", v, 3);
      rd(4'd7, v); chk("R6 stopped with C flag", v, 32'h1);
      wr(4'd1, 32'h1);
      idle(10);
      rd(4'd8, v); chk("R6 resumes after enable", {31'd0, (v > 3 && v < 10)}, 1);
      wr(4'd1, 32'h2);

      // R7 C wins over A
      wr(4'd0, 32'h0);
      wr(4'd2, 32'd2);
      wr(4'd3, 32'd6);
      wr(4'd1, 32'h5);
      idle(9);
      chk("R7 high after A", {31'd0, wave16}, 1);
      wr(4'd2, 32'd7);
      wr(4'd3, 32'd7);
      idle(8);
      chk("R7 C wins on joint match", {31'd0, wave16}, 0);
      wr(4'd1, 32'h2);

      // R4 / R7 / R11 square wave and full wrap
      rd(4'd7, v);
      wr(4'd2, 32'h100);
      wr(4'd3, 32'h200);
      wr(4'd1, 32'h5);
      idle(511);  chk("R7 low before A", {31'd0, wave16}, 0);
      idle(1);    chk("R7 rises at A", {31'd0, wave16}, 1);
      idle(511);  chk("R7 high before C", {31'd0, wave16}, 1);
      idle(1);    chk("R7 falls at C", {31'd0, wave16}, 0);
      idle(131072 - 1024);
      rd(4'd8, v); chk("R4 wraps to zero", v, 0);
      chk("R11 32-bit counter keeps counting", rdata32, 32'h10000);
      chk("R7 wrap not an A match", {31'd0, wave16}, 0);
      rd(4'd7, v); chk("R4 overflow flag", v, 32'hF);
      wr(4'd1, 32'h2);

      // R8 mask and interrupt
      rd(4'd7, v);
      wr(4'd4, 32'h1);
      rd(4'd6, v); chk("R8 set mask", v, 1);
      wr(4'd4, 32'h4);
      rd(4'd6, v); chk("R8 set second bit", v, 5);
      wr(4'd5, 32'h1);
      rd(4'd6, v); chk("R8 clear mask", v, 4);
      chk("R8 irq idle", {31'd0, irq16}, 0);
      wr(4'd3, 32'd2);
      wr(4'd0, 32'h10);
      wr(4'd1, 32'h5);
      idle(10);
      chk("R8 masked flag gives no irq", {31'd0, irq16}, 0);
      wr(4'd4, 32'h1);
      chk("R8 unmasked flag raises irq", {31'd0, irq16}, 1);
      rd(4'd7, v);
      chk("R9 read clears, irq drops", {31'd0, irq16}, 0);

      // R10 / R11 readback
      wr(4'd2, 32'h12345678);
      rd(4'd2, v); chk("R11 16-bit compare", v, 32'h5678);
      chk("R11 32-bit compare", rdata32, 32'h12345678);
      wr(4'd0, 32'hFF);
      rd(4'd0, v); chk("R10 mode readback", v, 32'h1F);
      rd(4'd1, v); chk("R10 write-only reads zero", v, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule